// File: doc/BRIEF.md
# Instruction Fetch Address Mapper

This block turns a word-granular program counter into a fetch destination. It forms the byte address of the fetch by appending two zero bits to the counter. The top bit of that byte address picks which of two map registers applies, so the program space is split into a lower and an upper half. Each half is redirected on its own, either to the on-chip instruction memory or to a numbered segment of the unified memory.

The map registers are loaded through two write ports, one per register. A new value applies from the cycle after the write. A bitmap input tells the block which unified segments are backed by storage. A fetch that lands in an absent segment raises a fault flag, but only while the fetch-valid input is high. The block decides the target and the address only; the memory arrays and the fetched data lie outside it.

Top module: `ifm_mapper`

## Requirements
- R1: `byteAddr` equals `pcIn` shifted left by two, with bits 1:0 zero, in every cycle.
- R2: When bit 17 of the byte address (the top bit of `pcIn`) is clear, the first map register decides the target. When it is set, the second map register decides.
- R3: When bit 12 of the selected map register is 1, `tgtUnified` is 0 (internal instruction memory), `tgtSeg` reads 0 and `busFault` is 0.
- R4: When bit 12 of the selected map register is 0, `tgtUnified` is 1 and `tgtSeg` equals bits 7:0 of that register.
- R5: `busFault` is 1 exactly when `fetchValid` is 1, the target is unified and bit `tgtSeg` of `segPresent` is 0.
- R6: While `fetchValid` is 0, `busFault` stays 0 whatever the mapping and the bitmap.
- R7: Reset loads both map registers with 0x1000, so after reset both halves fetch from internal memory with no fault.
- R8: A map write changes the outputs from the next cycle on. In the write cycle itself the outputs still follow the old value.
- R9: Bits 15:13 and 11:8 of a written map value have no effect on any output.
- R10: A write to one map register leaves the mapping of the other half unchanged. Both registers may be written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pcIn | input | 16 | Word-granular program counter |
| fetchValid | input | 1 | A fetch is requested this cycle |
| map0WrEn | input | 1 | Write strobe for the lower-half map register |
| map0WrData | input | 16 | Value for the lower-half map register |
| map1WrEn | input | 1 | Write strobe for the upper-half map register |
| map1WrData | input | 16 | Value for the upper-half map register |
| segPresent | input | 256 | One bit per unified segment; 1 means backed by storage |
| tgtUnified | output | 1 | 0 = internal instruction memory, 1 = unified segment |
| tgtSeg | output | 8 | Unified segment number, 0 for internal targets |
| byteAddr | output | 18 | Byte address of the fetch |
| busFault | output | 1 | Fetch from an absent unified segment |

## Verification
Directed cases come first. Both halves are fetched from right after reset, to tell the reset value apart from a zero reset. A write to the lower map register is followed by fetches from both halves, which separates a correct half select from a shared or swapped register. Values with the ignored bits set, and with bit 12 set over a non-zero segment field, show whether the decode looks at the right fields. A fault case is tried with `fetchValid` high and low and with the segment bit present and absent, to isolate each term of the fault condition. Random program counters, map writes (single and simultaneous) and bitmaps then cover the mix, with every write cycle checked against the old mapping.

// File: rtl/ifm_pkg.sv
package ifm_pkg;

  localparam int NUM_MAPS = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_MAPS-1:0] wrStb;     // per-register load strobe
    logic                hiHalf;    // fetch lies in the upper half
    logic                fetchQual; // fault may be reported
  } ifm_ctrl_t;

endpackage

// File: rtl/ifm_ctrl.sv
module ifm_ctrl #(
  parameter int PC_W = 16
) (
  input  logic [PC_W-1:0]  pcIn,
  input  logic             fetchValid,
  input  logic             map0WrEn,
  input  logic             map1WrEn,
  output ifm_pkg::ifm_ctrl_t ctrlStb
);

  // The top bit of the byte address {pcIn,2'b00} is the top bit of pcIn.
  localparam int HALF_BIT = PC_W - 1;

  always_comb begin
    ctrlStb           = '0;
    ctrlStb.wrStb[0]  = map0WrEn;
    ctrlStb.wrStb[1]  = map1WrEn;
    ctrlStb.hiHalf    = pcIn[HALF_BIT];
    ctrlStb.fetchQual = fetchValid;
  end

endmodule

// File: rtl/ifm_datapath.sv
module ifm_datapath #(
  parameter int          PC_W      = 16,
  parameter int          MAP_W     = 16,
  parameter int          INT_BIT   = 12,
  parameter int          SEG_W     = 8,
  parameter logic [15:0] RESET_MAP = 16'h1000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ifm_pkg::ifm_ctrl_t     ctrlStb,
  input  logic [PC_W-1:0]        pcIn,
  input  logic [MAP_W-1:0]       map0WrData,
  input  logic [MAP_W-1:0]       map1WrData,
  input  logic [(1<<SEG_W)-1:0]  segPresent,
  output logic                   tgtUnified,
  output logic [SEG_W-1:0]       tgtSeg,
  output logic [PC_W+1:0]        byteAddr,
  output logic                   busFault
);

  import ifm_pkg::*;

  localparam int ADDR_W = PC_W + 2;

  // Only the decoded fields of each map value are kept (R9).
  logic [MAP_W-1:0] wrData  [NUM_MAPS];
  logic             mapInt  [NUM_MAPS];
  logic [SEG_W-1:0] mapSeg  [NUM_MAPS];

  assign wrData[0] = map0WrData;
  assign wrData[1] = map1WrData;

  // Fields with no function, folded away on purpose.
  logic unusedMapBits;
  assign unusedMapBits = ^{map0WrData[MAP_W-1:INT_BIT+1], map0WrData[INT_BIT-1:SEG_W],
                           map1WrData[MAP_W-1:INT_BIT+1], map1WrData[INT_BIT-1:SEG_W]};

  for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mapInt[g] <= RESET_MAP[INT_BIT];
        mapSeg[g] <= RESET_MAP[SEG_W-1:0];
      end else if (ctrlStb.wrStb[g]) begin
        mapInt[g] <= wrData[g][INT_BIT];
        mapSeg[g] <= wrData[g][SEG_W-1:0];
      end
    end
  end

  logic             selInt;
  logic [SEG_W-1:0] selSeg;
  logic             unifiedHit;

  always_comb begin
    selInt     = ctrlStb.hiHalf ? mapInt[1] : mapInt[0];
    selSeg     = ctrlStb.hiHalf ? mapSeg[1] : mapSeg[0];
    unifiedHit = ~selInt;
    tgtUnified = unifiedHit;
    tgtSeg     = unifiedHit ? selSeg : '0;
    byteAddr   = ADDR_W'({pcIn, 2'b00});
    busFault   = ctrlStb.fetchQual & unifiedHit & ~segPresent[selSeg];
  end

endmodule

// File: rtl/ifm_mapper.sv
module ifm_mapper #(
  parameter int          PC_W      = 16,
  parameter int          MAP_W     = 16,
  parameter int          INT_BIT   = 12,
  parameter int          SEG_W     = 8,
  parameter logic [15:0] RESET_MAP = 16'h1000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PC_W-1:0]       pcIn,
  input  logic                  fetchValid,
  input  logic                  map0WrEn,
  input  logic [MAP_W-1:0]      map0WrData,
  input  logic                  map1WrEn,
  input  logic [MAP_W-1:0]      map1WrData,
  input  logic [(1<<SEG_W)-1:0] segPresent,
  output logic                  tgtUnified,
  output logic [SEG_W-1:0]      tgtSeg,
  output logic [PC_W+1:0]       byteAddr,
  output logic                  busFault
);

  ifm_pkg::ifm_ctrl_t ctrlStb;

  ifm_ctrl #(.PC_W(PC_W)) u_ctrl (
    .pcIn       (pcIn),
    .fetchValid (fetchValid),
    .map0WrEn   (map0WrEn),
    .map1WrEn   (map1WrEn),
    .ctrlStb    (ctrlStb)
  );

  ifm_datapath #(
    .PC_W(PC_W), .MAP_W(MAP_W), .INT_BIT(INT_BIT),
    .SEG_W(SEG_W), .RESET_MAP(RESET_MAP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlStb    (ctrlStb),
    .pcIn       (pcIn),
    .map0WrData (map0WrData),
    .map1WrData (map1WrData),
    .segPresent (segPresent),
    .tgtUnified (tgtUnified),
    .tgtSeg     (tgtSeg),
    .byteAddr   (byteAddr),
    .busFault   (busFault)
  );

endmodule

// File: rtl/ifm_mapper_chk.sv
module ifm_mapper_chk #(
  parameter int          PC_W      = 16,
  parameter int          MAP_W     = 16,
  parameter int          INT_BIT   = 12,
  parameter int          SEG_W     = 8,
  parameter logic [15:0] RESET_MAP = 16'h1000
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [PC_W-1:0]       pcIn,
  input logic                  fetchValid,
  input logic                  map0WrEn,
  input logic [MAP_W-1:0]      map0WrData,
  input logic                  map1WrEn,
  input logic [MAP_W-1:0]      map1WrData,
  input logic [(1<<SEG_W)-1:0] segPresent,
  input logic                  tgtUnified,
  input logic [SEG_W-1:0]      tgtSeg,
  input logic [PC_W+1:0]       byteAddr,
  input logic                  busFault
);

  // shadow of the map values, rebuilt from the write ports
  logic [MAP_W-1:0] shadow0, shadow1;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow0 <= MAP_W'(RESET_MAP);
      shadow1 <= MAP_W'(RESET_MAP);
    end else begin
      if (map0WrEn) shadow0 <= map0WrData;
      if (map1WrEn) shadow1 <= map1WrData;
    end
  end

  logic [MAP_W-1:0] shadowSel;
  assign shadowSel = pcIn[PC_W-1] ? shadow1 : shadow0;

  // R2 and R8: target follows the value held before any write this cycle
  p_half_select_r2: assert property (@(posedge clk) disable iff (!rstN)
    tgtUnified == !shadowSel[INT_BIT]);

  p_seg_field_r4: assert property (@(posedge clk) disable iff (!rstN)
    tgtUnified |-> tgtSeg == shadowSel[SEG_W-1:0]);

  p_internal_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !tgtUnified |-> (tgtSeg == '0) && !busFault);

  p_fault_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    busFault |-> tgtUnified && !segPresent[tgtSeg]);

  p_fault_raise_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && tgtUnified && !segPresent[tgtSeg]) |-> busFault);

  p_no_fetch_r6: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |-> !busFault);

  p_write_next_r8: assert property (@(posedge clk) disable iff (!rstN)
    (map0WrEn && !map1WrEn) |=> (!pcIn[PC_W-1] -> (tgtUnified == !$past(map0WrData[INT_BIT]))));

  p_addr_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    byteAddr[1:0] == 2'b00);

endmodule

bind ifm_mapper ifm_mapper_chk #(
  .PC_W(PC_W), .MAP_W(MAP_W), .INT_BIT(INT_BIT),
  .SEG_W(SEG_W), .RESET_MAP(RESET_MAP)
) u_chk (
  .clk(clk), .rstN(rstN), .pcIn(pcIn), .fetchValid(fetchValid),
  .map0WrEn(map0WrEn), .map0WrData(map0WrData),
  .map1WrEn(map1WrEn), .map1WrData(map1WrData),
  .segPresent(segPresent), .tgtUnified(tgtUnified), .tgtSeg(tgtSeg),
  .byteAddr(byteAddr), .busFault(busFault)
);

// File: tb/ifm_mapper_bench.sv
module ifm_mapper_bench;

  localparam real CLK_NS = 8.0;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [15:0]  pcIn = '0;
  logic         fetchValid = 1'b0;
  logic         map0WrEn = 1'b0;
  logic [15:0]  map0WrData = '0;
  logic         map1WrEn = 1'b0;
  logic [15:0]  map1WrData = '0;
  logic [255:0] segPresent = '0;
  logic         tgtUnified;
  logic [7:0]   tgtSeg;
  logic [17:0]  byteAddr;
  logic         busFault;

  int testsRun = 0;
  int testsFailed = 0;

  // bench model of the two map values
  logic [15:0] model0 = 16'h1000;
  logic [15:0] model1 = 16'h1000;

  always #(CLK_NS/2) clk = ~clk;

  ifm_mapper u_ifm_mapper (
    .clk(clk), .rstN(rstN), .pcIn(pcIn), .fetchValid(fetchValid),
    .map0WrEn(map0WrEn), .map0WrData(map0WrData),
    .map1WrEn(map1WrEn), .map1WrData(map1WrData),
    .segPresent(segPresent), .tgtUnified(tgtUnified), .tgtSeg(tgtSeg),
    .byteAddr(byteAddr), .busFault(busFault)
  );

  function automatic logic [15:0] pickMap(input logic [15:0] pc);
    return pc[15] ? model1 : model0;
  endfunction

  function automatic logic expUnified(input logic [15:0] pc);
    logic [15:0] m = pickMap(pc);
    return !m[12];
  endfunction

  function automatic logic [7:0] expSeg(input logic [15:0] pc);
    logic [15:0] m = pickMap(pc);
    return m[12] ? 8'h00 : m[7:0];
  endfunction

  function automatic logic expFault(input logic [15:0] pc, input logic fv,
                                    input logic [255:0] pres);
    return fv && expUnified(pc) && !pres[expSeg(pc)];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic checkOutputs(input string req);
    check("R1", "byteAddr", 32'(byteAddr), 32'({pcIn, 2'b00}));
    check(req, "tgtUnified", 32'(tgtUnified), 32'(expUnified(pcIn)));
    check(req, "tgtSeg", 32'(tgtSeg), 32'(expSeg(pcIn)));
    check(req, "busFault", 32'(busFault), 32'(expFault(pcIn, fetchValid, segPresent)));
  endtask

  // one cycle: drive at negedge, check before the edge, update model after it
  task automatic runCycle(input logic [15:0] pc, input logic fv,
                          input logic w0, input logic [15:0] d0,
                          input logic w1, input logic [15:0] d1,
                          input string req);
    @(negedge clk);
    pcIn = pc; fetchValid = fv;
    map0WrEn = w0; map0WrData = d0;
    map1WrEn = w1; map1WrData = d1;
    #1;
    checkOutputs(req);
    @(posedge clk);
    if (w0) model0 = d0;
    if (w1) model1 = d1;
  endtask

  function automatic logic [255:0] randBitmap();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    #(CLK_NS * 200000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));

    // R7: during reset and after it, both halves internal
    @(negedge clk);
    pcIn = 16'h0010; fetchValid = 1'b1;
    #1;
    checkOutputs("R7");
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    runCycle(16'h0010, 1'b1, 0, '0, 0, '0, "R7");
    runCycle(16'h8004, 1'b1, 0, '0, 0, '0, "R7");

    // R8: write lower map to unified seg 5; write cycle still internal
    segPresent = '0;
    runCycle(16'h0001, 1'b1, 1, 16'h0005, 0, '0, "R8");
    runCycle(16'h0001, 1'b1, 0, '0, 0, '0, "R4");
    check("R5", "fault absent seg", 32'(busFault), 32'd1);
    runCycle(16'h0001, 1'b0, 0, '0, 0, '0, "R6");
    check("R6", "fault without fetch", 32'(busFault), 32'd0);
    // R10: upper half untouched
    runCycle(16'h8001, 1'b1, 0, '0, 0, '0, "R10");
    check("R10", "upper internal", 32'(tgtUnified), 32'd0);
    segPresent[5] = 1'b1;
    runCycle(16'h0002, 1'b1, 0, '0, 0, '0, "R5");

    // R9: ignored bits set, segment 3 absent
    runCycle(16'hC000, 1'b1, 0, '0, 1, 16'hEF03, "R9");
    runCycle(16'hC000, 1'b1, 0, '0, 0, '0, "R9");
    check("R2", "upper seg", 32'(tgtSeg), 32'd3);
    // R3: internal bit over a non-zero segment field
    runCycle(16'hC000, 1'b1, 0, '0, 1, 16'h1FFF, "R3");
    runCycle(16'hC000, 1'b1, 0, '0, 0, '0, "R3");
    check("R3", "internal seg zero", 32'(tgtSeg), 32'd0);
    // R10: both written in one cycle
    runCycle(16'h7FFF, 1'b1, 1, 16'h00A0, 1, 16'h00B1, "R10");
    runCycle(16'h7FFF, 1'b1, 0, '0, 0, '0, "R2");
    runCycle(16'hFFFF, 1'b1, 0, '0, 0, '0, "R2");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] d0, d1;
      logic w0, w1;
      segPresent = randBitmap();
      d0 = 16'($urandom); d1 = 16'($urandom);
      w0 = ($urandom % 4) == 0;
      w1 = ($urandom % 4) == 0;
      runCycle(16'($urandom), 1'($urandom), w0, d0, w1, d1, "R2");
    end

    @(negedge clk);
    map0WrEn = 1'b0; map1WrEn = 1'b0;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule